// File: doc/BRIEF.md
# Aggressor-Victim Interconnect Test Sequencer

This block produces the stimulus for a crosstalk test of a bundle of vertical die-to-die links. One shared controller steps through eight aggressor/victim vector pairs. During each step it drives one victim value and one aggressor value. A one-hot selection vector marks which victim group is under test. Logic outside this block steers the victim value onto the links of the marked group and the aggressor value onto all other links. Response analysis also happens outside.

A pulse on the start input launches a test phase. The number of victim groups is sampled with that pulse. The first group is marked and the eight-step sequence runs once. After the eighth step the sequencer does one of two things. If more groups remain, it strobes a shift that moves the mark to the next group and repeats the sequence. If the last group has run, it pulses a done flag and returns to idle. In idle the link works in normal mode: no group is marked and every stimulus output is low.

Top module: `avt_seq_gen`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, sel_o is zero and victim_o, aggr_o, shift_o and done_o are all 0.
- R2: A start_i high in an idle cycle makes the next cycle the first pattern step, with sel_o equal to 1 (bit 0 marks the first group).
- R3: The eight pattern steps drive (victim_o, aggr_o) in this order: (0,0), (1,1), (0,1), (1,0), (0,0), (1,0), (0,1), (1,1).
- R4: In the eighth step of every group except the last, shift_o is 1 for exactly that cycle. In the following cycle sel_o has moved one bit upward and the sequence restarts at step one.
- R5: In the eighth step of the last group, done_o is 1 for exactly that cycle. The next cycle is idle with sel_o zero.
- R6: sel_o never has more than one bit set. While idle it is zero and victim_o, aggr_o, shift_o and done_o are 0.
- R7: start_i is ignored while a test phase runs. A change of set_cnt_i during a run has no effect either.
- R8: The group count is taken from set_cnt_i in the start cycle. A value of 0 is treated as 1, and a value above SET_MAX is treated as SET_MAX.
- R9: A phase with an effective count of w groups spends exactly 8*w cycles outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a test phase when idle |
| set_cnt_i | input | $clog2(SET_MAX+1) | Number of victim groups for the phase |
| victim_o | output | 1 | Value for links of the marked group |
| aggr_o | output | 1 | Value for all other links |
| shift_o | output | 1 | One-cycle strobe that advances the mark |
| done_o | output | 1 | One-cycle pulse at the end of the phase |
| sel_o | output | SET_MAX | One-hot mark of the active victim group |

## Verification
The cases hardest to reach from the ports are the clamping of out-of-range group counts and the attempts to disturb a running phase. A start pulse and a new set_cnt_i value in the middle of a phase must leave the remaining sequence unchanged. The bench runs phases with a count of zero, one, a middle value, exactly SET_MAX and above SET_MAX. In one run it injects a second start with a different count halfway through. Before each start it queues the full cycle-by-cycle expectation, including the idle cycles that follow. Any extra, missing or shifted step therefore shows up as a mismatch.

// File: rtl/avt_pkg.sv
package avt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_P1   = 4'd1,
    ST_P2   = 4'd2,
    ST_P3   = 4'd3,
    ST_P4   = 4'd4,
    ST_P5   = 4'd5,
    ST_P6   = 4'd6,
    ST_P7   = 4'd7,
    ST_P8   = 4'd8
  } avt_state_e;

  localparam int unsigned STEPS = 8;
  // bit k holds the value for pattern step k+1
  localparam logic [STEPS-1:0] DEF_PAT_V = 8'b1010_1010;
  localparam logic [STEPS-1:0] DEF_PAT_A = 8'b1100_0110;
endpackage

// File: rtl/avt_ctrl.sv
module avt_ctrl
  import avt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_set_i,
  output logic       load_o,
  output logic       shift_o,
  output logic       done_o,
  output logic       active_o,
  output logic [2:0] step_o
);
  avt_state_e state_q, state_d;
  logic [3:0] step_full;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_P1;
        load_o  = 1'b1;
      end
      ST_P1: state_d = ST_P2;
      ST_P2: state_d = ST_P3;
      ST_P3: state_d = ST_P4;
      ST_P4: state_d = ST_P5;
      ST_P5: state_d = ST_P6;
      ST_P6: state_d = ST_P7;
      ST_P7: state_d = ST_P8;
      ST_P8: begin
        if (last_set_i) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          shift_o = 1'b1;
          state_d = ST_P1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign step_full = 4'(state_q) - 4'd1;
  assign step_o    = step_full[2:0];
  assign active_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/avt_shift_cnt.sv
module avt_shift_cnt #(
  parameter int unsigned SET_MAX = 6,
  localparam int unsigned W_WIDTH = $clog2(SET_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic               clear_i,
  input  logic [W_WIDTH-1:0] set_cnt_i,
  output logic [SET_MAX-1:0] sel_o,
  output logic               last_o
);
  localparam logic [W_WIDTH-1:0] CNT_MAX = W_WIDTH'(SET_MAX);

  logic [SET_MAX-1:0] sel_q;
  logic [SET_MAX-1:0] last_mask;
  logic [W_WIDTH-1:0] w_q, w_eff;

  always_comb begin
    if (set_cnt_i == '0)         w_eff = W_WIDTH'(1);
    else if (set_cnt_i > CNT_MAX) w_eff = CNT_MAX;
    else                          w_eff = set_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      w_q   <= W_WIDTH'(1);
    end else if (load_i) begin
      sel_q <= SET_MAX'(1);
      w_q   <= w_eff;
    end else if (clear_i) begin
      sel_q <= '0;
    end else if (shift_i) begin
      sel_q <= sel_q << 1;
    end
  end

  for (genvar i = 0; i < SET_MAX; i++) begin : g_last
    assign last_mask[i] = (w_q == W_WIDTH'(i + 1));
  end

  assign sel_o  = sel_q;
  assign last_o = |(sel_q & last_mask);
endmodule

// File: rtl/avt_pattern.sv
module avt_pattern #(
  parameter logic [7:0] PAT_V = avt_pkg::DEF_PAT_V,
  parameter logic [7:0] PAT_A = avt_pkg::DEF_PAT_A
) (
  input  logic       active_i,
  input  logic [2:0] step_i,
  output logic       victim_o,
  output logic       aggr_o
);
  assign victim_o = active_i & PAT_V[step_i];
  assign aggr_o   = active_i & PAT_A[step_i];
endmodule

// File: rtl/avt_seq_gen.sv
module avt_seq_gen #(
  parameter int unsigned SET_MAX = 6,
  parameter logic [7:0]  PAT_V   = avt_pkg::DEF_PAT_V,
  parameter logic [7:0]  PAT_A   = avt_pkg::DEF_PAT_A,
  localparam int unsigned W_WIDTH = $clog2(SET_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [W_WIDTH-1:0] set_cnt_i,
  output logic               victim_o,
  output logic               aggr_o,
  output logic               shift_o,
  output logic               done_o,
  output logic [SET_MAX-1:0] sel_o
);
  logic       load, shift, done, active, last_set;
  logic [2:0] step;

  avt_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_set_i (last_set),
    .load_o     (load),
    .shift_o    (shift),
    .done_o     (done),
    .active_o   (active),
    .step_o     (step)
  );

  avt_shift_cnt #(.SET_MAX(SET_MAX)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .shift_i   (shift),
    .clear_i   (done),
    .set_cnt_i (set_cnt_i),
    .sel_o     (sel_o),
    .last_o    (last_set)
  );

  avt_pattern #(.PAT_V(PAT_V), .PAT_A(PAT_A)) i_pat (
    .active_i (active),
    .step_i   (step),
    .victim_o (victim_o),
    .aggr_o   (aggr_o)
  );

  assign shift_o = shift;
  assign done_o  = done;
endmodule

// File: rtl/avt_seq_gen_chk.sv
module avt_seq_gen_chk #(
  parameter int unsigned SET_MAX = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               victim_o,
  input logic               aggr_o,
  input logic               shift_o,
  input logic               done_o,
  input logic [SET_MAX-1:0] sel_o
);
  a_r6_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) |-> (!victim_o && !aggr_o && !shift_o && !done_o));

  a_r2_start_marks_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0 && start_i) |=> (sel_o == SET_MAX'(1)));

  a_r4_shift_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> (sel_o == ($past(sel_o) << 1)));

  a_r5_done_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (sel_o == '0 && !done_o));

  a_r4_shift_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_o && done_o));

  a_r7_mark_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != '0 && !shift_o && !done_o) |=> $stable(sel_o));
endmodule

bind avt_seq_gen avt_seq_gen_chk #(.SET_MAX(SET_MAX)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .victim_o (victim_o),
  .aggr_o   (aggr_o),
  .shift_o  (shift_o),
  .done_o   (done_o),
  .sel_o    (sel_o)
);

// File: tb/test_avt_seq_gen.sv
module test_avt_seq_gen;
  localparam int unsigned SET_MAX = 6;
  localparam int unsigned W_WIDTH = $clog2(SET_MAX + 1);

  typedef struct {
    logic               v;
    logic               a;
    logic               sh;
    logic               dn;
    logic [SET_MAX-1:0] sel;
    string              tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W_WIDTH-1:0] set_cnt = '0;
  logic victim, aggr, shift, done;
  logic [SET_MAX-1:0] sel;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // expected (victim, aggr) per step 1..8
  localparam logic [7:0] EV = 8'b1010_1010;
  localparam logic [7:0] EA = 8'b1100_0110;

  always #10 clk = ~clk;

  avt_seq_gen #(.SET_MAX(SET_MAX)) i_avt_seq_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .set_cnt_i (set_cnt),
    .victim_o  (victim),
    .aggr_o    (aggr),
    .shift_o   (shift),
    .done_o    (done),
    .sel_o     (sel)
  );

  task automatic check_now(string tag, logic v, logic a, logic sh, logic dn,
                           logic [SET_MAX-1:0] s);
    checks++;
    if ({victim, aggr, shift, done, sel} !== {v, a, sh, dn, s}) begin
      errors++;
      $display("FAIL %s: got v=%b a=%b sh=%b dn=%b sel=%b, exp v=%b a=%b sh=%b dn=%b sel=%b",
               tag, victim, aggr, shift, done, sel, v, a, sh, dn, s);
    end
  endtask

  // monitor: one expected item per cycle while queue is non-empty
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_now(e.tag, e.v, e.a, e.sh, e.dn, e.sel);
    end
  end

  function automatic int eff_cnt(int n);
    if (n == 0) return 1;          // R8 low clamp
    if (n > SET_MAX) return SET_MAX; // R8 high clamp
    return n;
  endfunction

  task automatic push_phase(int n);
    int w = eff_cnt(n);
    for (int s = 0; s < w; s++) begin
      for (int k = 0; k < 8; k++) begin
        exp_t e;
        e.v   = EV[k];
        e.a   = EA[k];
        e.sh  = (k == 7) && (s != w - 1);
        e.dn  = (k == 7) && (s == w - 1);
        e.sel = SET_MAX'(1) << s;
        e.tag = (k == 7) ? ((s == w - 1) ? "R5" : "R4") : ((s == 0 && k == 0) ? "R2" : "R3");
        q.push_back(e);
      end
    end
    for (int i = 0; i < 2; i++) begin
      exp_t e;
      e.v = 0; e.a = 0; e.sh = 0; e.dn = 0; e.sel = '0;
      e.tag = "R9";  // phase length exactly 8*w, then idle
      q.push_back(e);
    end
  endtask

  // driver: R7 disturb = start pulse plus new count mid-phase
  task automatic run_phase(int n, bit disturb);
    @(negedge clk);
    set_cnt = W_WIDTH'(n);
    start = 1'b1;
    @(posedge clk);
    push_phase(n);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      set_cnt = W_WIDTH'(1);
      start = 1'b1;   // R7: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check_now("R1", 0, 0, 0, 0, '0);   // during reset
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_now("R1", 0, 0, 0, 0, '0);   // after release
    // R6: idle with start low stays quiet
    repeat (2) @(negedge clk);
    #1 check_now("R6", 0, 0, 0, 0, '0);
    run_phase(1, 0);
    run_phase(3, 0);
    run_phase(0, 0);              // R8 zero clamp
    run_phase(SET_MAX, 0);
    run_phase(SET_MAX + 1, 0);    // R8 high clamp
    run_phase(4, 1);              // R7
    run_phase(2, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule